// File: doc/BRIEF.md
# Serial EEPROM Station Address Loader

This block fetches a 48-bit station address from a small three-wire serial EEPROM. After a one-cycle start request it runs three separate read transactions, one for each of the words at EEPROM addresses 0, 1 and 2. Each transaction is framed by its own chip-select pulse. Each 16-bit word is then split into bytes and placed into a six-byte address register. When the third word is in place the block raises a valid level and gives a one-cycle done pulse.

The serial clock comes from the system clock. Each clock level lasts `HALF_CYC` system cycles. Every transaction has the same bit sequence:

1. A setup half-period with select high and data low.
2. A leading zero bit.
3. The three read opcode bits.
4. An 8-bit word address, sent most significant bit first.
5. One discarded input bit.
6. Sixteen data bits, received most significant bit first.

The serial data input from the EEPROM passes through a two-flop synchronizer before it is sampled. The sample point is the end of each clock-low phase.

The address leaves the block as a held register qualified by a level. There is no back-pressure: a consumer may read `mac_o` at any time while `valid_o` is high. The value stays valid until the next start or reset.

Top module: `eeprom_addr_loader`

## Requirements
- R1: After a synchronous reset, and whenever the block is not busy, select, serial clock and serial data out are all low. Busy, done and valid are low, and the address register reads zero after reset.
- R2: A transaction raises select while the serial clock and data out are low. The first rising serial clock edge comes exactly two half-periods after select rises, and data out stays low until then. The serial clock is never high while select is low.
- R3: The bits sent on data out, sampled at rising clock edges, are a 0, then the read opcode 1, 1, 0, then the 8-bit word index, most significant bit first. Data out does not change while the serial clock is high.
- R4: Every high level of the serial clock lasts exactly `HALF_CYC` system cycles. No level of the serial clock lasts less than that.
- R5: After the address, the first input bit is discarded. The next 16 input bits form the word, most significant bit first.
- R6: One start produces exactly three transactions, for word indices 0, 1 and 2 in that order. Octets are numbered 0 to 5, with octet 0 in `mac_o[47:40]` and octet 5 in `mac_o[7:0]`. Octet 2k is the low byte of word k and octet 2k+1 is its high byte.
- R7: Between transactions select stays low, with clock and data low, for at least `HALF_CYC` cycles.
- R8: A start request is ignored while busy. It neither adds transactions nor changes the cycle at which done appears.
- R9: Done is a single-cycle pulse. It becomes visible 180·`HALF_CYC`+3 cycles after the clock edge that accepted start. Valid rises with done and holds. An accepted start clears valid and the address register on that same edge.
- R10: A reset asserted during a transfer returns all pins low, clears busy, valid and the address register, and no transaction resumes after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to load the address; ignored while busy |
| busy_o | output | 1 | High from accepted start until the last word is stored |
| done_o | output | 1 | One-cycle pulse when all three words are stored |
| valid_o | output | 1 | Address register holds a complete address |
| mac_o | output | 48 | Assembled station address, octet 0 in bits 47:40 |
| ee_cs_o | output | 1 | EEPROM chip select |
| ee_sk_o | output | 1 | EEPROM serial clock |
| ee_di_o | output | 1 | Serial data toward the EEPROM |
| ee_do_i | input | 1 | Serial data from the EEPROM (asynchronous) |

## Verification
The bench places a behavioural EEPROM on the pins. The model decodes each command and returns a poison word for any index other than 0 to 2. A design that reversed the address bit order, dropped the leading zero or sent a wrong opcode would therefore show up both in a protocol error count and in a wrong assembled address. Word patterns with asymmetric bytes and single edge bits expose a swapped byte order, a missing skipped input bit (the result shifts by one) and an LSB-first capture.

A second start during a transfer is checked against the exact done cycle and the transaction count, which catches a design that restarts. A reset in the middle of a run is checked for cleared outputs and for silence on the pins afterwards. The pin monitor measures setup length, clock high time and select gaps, which catches a divider that is off by one or a missing gap.

// File: rtl/eal_pkg.sv
package eal_pkg;

  // Read opcode, shifted out MSB first after the leading zero bits.
  localparam logic [2:0] RD_OPCODE  = 3'b110;
  // Zero bits sent before the opcode.
  localparam int         LEAD_ZEROS = 1;
  // Input bits clocked and thrown away before the data word.
  localparam int         SKIP_BITS  = 1;

  typedef struct packed {
    logic cs;
    logic sk;
    logic di;
  } pins_t;

  localparam pins_t PINS_IDLE = '{cs: 1'b0, sk: 1'b0, di: 1'b0};

  typedef enum logic {CTL_IDLE, CTL_RUN} ctl_e;

endpackage

// File: rtl/eal_tick.sv
// Half-period strobe for the serial clock: one pulse every HALF_CYC cycles while enabled.
module eal_tick #(
  parameter int HALF_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic tick
);
  localparam int            CW   = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (en) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  assign tick = en && (cnt == LAST);

endmodule

// File: rtl/eal_sync.sv
// Synchronizer chain for the asynchronous serial data returned by the EEPROM.
module eal_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/eal_word_xfer.sv
// One framed read transaction. The step index counts half-periods:
//   0                  setup (select high, clock low, data low)
//   1 .. CMD_END       command bits, two steps each (low, high)
//   .. DATA_END        input bits, two steps each (low, high)
//   LAST_STEP          gap with all pins low
module eal_word_xfer import eal_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              tick,
  input  logic [ADDR_W-1:0] word_addr,
  input  logic              din,
  output logic              active,
  output logic              cs_o,
  output logic              sk_o,
  output logic              di_o,
  output logic [WORD_W-1:0] word_q,
  output logic              word_done
);
  localparam int CMD_BITS  = LEAD_ZEROS + 3 + ADDR_W;
  localparam int IN_BITS   = SKIP_BITS + WORD_W;
  localparam int CMD_END   = 2 * CMD_BITS;
  localparam int DATA_END  = CMD_END + 2 * IN_BITS;
  localparam int LAST_STEP = DATA_END + 1;
  localparam int STEP_W    = $clog2(LAST_STEP + 1);

  logic [STEP_W-1:0]   step;
  pins_t               pins_q;
  logic [WORD_W-1:0]   shift_q;
  logic [CMD_BITS-1:0] cmd;
  int                  si;
  int                  rel;
  logic                capture_now;
  logic                last_now;

  assign cmd = {{LEAD_ZEROS{1'b0}}, RD_OPCODE, word_addr};

  // Pin levels for a given step index.
  function automatic pins_t pins_at(input int s, input logic [CMD_BITS-1:0] c);
    pins_t               p;
    logic [CMD_BITS-1:0] t;
    int                  k;
    p = PINS_IDLE;
    if (s == 0) begin
      p.cs = 1'b1;
    end else if (s <= CMD_END) begin
      k    = (s - 1) / 2;
      t    = c << k;
      p.cs = 1'b1;
      p.sk = ((s - 1) % 2) == 1;
      p.di = t[CMD_BITS-1];
    end else if (s <= DATA_END) begin
      p.cs = 1'b1;
      p.sk = ((s - 1 - CMD_END) % 2) == 1;
    end
    return p;
  endfunction

  always_comb begin
    si          = int'(step);
    rel         = si - 1 - CMD_END;
    capture_now = (si > CMD_END) && (si <= DATA_END) && ((rel % 2) == 0) &&
                  ((rel / 2) >= SKIP_BITS);
    last_now    = (si == LAST_STEP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      step      <= '0;
      pins_q    <= PINS_IDLE;
      shift_q   <= '0;
      word_done <= 1'b0;
    end else begin
      word_done <= 1'b0;
      if (go) begin
        active  <= 1'b1;
        step    <= '0;
        pins_q  <= pins_at(0, cmd);
        shift_q <= '0;
      end else if (tick) begin
        // Sampling at the end of a low phase: the clock is about to rise.
        if (capture_now) shift_q <= {shift_q[WORD_W-2:0], din};
        if (last_now) begin
          active    <= 1'b0;
          pins_q    <= PINS_IDLE;
          word_done <= 1'b1;
        end else begin
          step   <= step + 1'b1;
          pins_q <= pins_at(si + 1, cmd);
        end
      end
    end
  end

  assign cs_o   = pins_q.cs;
  assign sk_o   = pins_q.sk;
  assign di_o   = pins_q.di;
  assign word_q = shift_q;

endmodule

// File: rtl/eeprom_addr_loader.sv
module eeprom_addr_loader import eal_pkg::*; #(
  parameter int HALF_CYC    = 4,
  parameter int ADDR_W      = 8,
  parameter int WORD_W      = 16,
  parameter int NUM_WORDS   = 3,
  parameter int SYNC_STAGES = 2,
  parameter int BASE_ADDR   = 0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        valid_o,
  output logic [47:0] mac_o,
  output logic        ee_cs_o,
  output logic        ee_sk_o,
  output logic        ee_di_o,
  input  logic        ee_do_i
);
  localparam int               MAC_W    = NUM_WORDS * WORD_W;
  localparam int               BPW      = WORD_W / 8;
  localparam int               IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

  ctl_e              state;
  logic [IDX_W-1:0]  widx;
  logic [MAC_W-1:0]  mac_q;
  logic              done_q;
  logic              valid_q;

  logic              launch;
  logic              more;
  logic              go;
  logic              tick;
  logic              xfer_active;
  logic              din_sync;
  logic [WORD_W-1:0] word_q;
  logic              word_done;
  logic [ADDR_W-1:0] word_addr;

  // A start is only taken in idle; the next word is launched in the same
  // cycle that the previous one reports completion.
  assign launch    = (state == CTL_IDLE) && start_i;
  assign more      = (state == CTL_RUN) && word_done && (widx != LAST_IDX);
  assign go        = launch || more;
  assign word_addr = ADDR_W'(BASE_ADDR) + ADDR_W'(widx);

  eal_tick #(.HALF_CYC(HALF_CYC)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .clr  (go),
    .en   (xfer_active),
    .tick (tick)
  );

  eal_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (ee_do_i),
    .q   (din_sync)
  );

  eal_word_xfer #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_xfer (
    .clk       (clk),
    .rst       (rst),
    .go        (go),
    .tick      (tick),
    .word_addr (word_addr),
    .din       (din_sync),
    .active    (xfer_active),
    .cs_o      (ee_cs_o),
    .sk_o      (ee_sk_o),
    .di_o      (ee_di_o),
    .word_q    (word_q),
    .word_done (word_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= CTL_IDLE;
      widx    <= '0;
      mac_q   <= '0;
      done_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (launch) begin
        state   <= CTL_RUN;
        widx    <= '0;
        mac_q   <= '0;
        valid_q <= 1'b0;
      end else if ((state == CTL_RUN) && word_done) begin
        // Low byte of each word lands in the lower-numbered octet.
        for (int w = 0; w < NUM_WORDS; w++) begin
          if (widx == IDX_W'(w)) begin
            for (int b = 0; b < BPW; b++) begin
              mac_q[MAC_W-1-8*(w*BPW+b) -: 8] <= word_q[8*b +: 8];
            end
          end
        end
        if (widx == LAST_IDX) begin
          state   <= CTL_IDLE;
          done_q  <= 1'b1;
          valid_q <= 1'b1;
        end else begin
          widx <= widx + 1'b1;
        end
      end
    end
  end

  assign busy_o  = (state == CTL_RUN);
  assign done_o  = done_q;
  assign valid_o = valid_q;
  assign mac_o   = 48'(mac_q);

endmodule

// File: rtl/eal_checker.sv
module eal_checker #(
  parameter int HALF_CYC = 4
) (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic valid,
  input logic cs,
  input logic sk,
  input logic di
);
  logic        sk_q;
  logic [15:0] sk_hold;
  logic [15:0] cs_low;

  // Cycles each serial clock level and each deselected gap have lasted.
  always_ff @(posedge clk) begin
    if (rst) begin
      sk_q    <= 1'b0;
      sk_hold <= 16'hFFFF;
      cs_low  <= 16'hFFFF;
    end else begin
      sk_q    <= sk;
      sk_hold <= (sk != sk_q) ? 16'd1 : ((sk_hold == 16'hFFFF) ? sk_hold : sk_hold + 16'd1);
      cs_low  <= cs ? 16'd0 : ((cs_low == 16'hFFFF) ? cs_low : cs_low + 16'd1);
    end
  end

  assert_idle_pins_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!cs && !sk && !di));

  assert_cs_rise_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(cs) |-> (!sk && !di));

  assert_sk_in_frame_R2: assert property (@(posedge clk) disable iff (rst)
    sk |-> cs);

  assert_di_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (sk && $past(sk)) |-> $stable(di));

  assert_sk_half_R4: assert property (@(posedge clk) disable iff (rst)
    (sk != sk_q) |-> (sk_hold >= 16'(HALF_CYC)));

  assert_cs_gap_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(cs) |-> (cs_low >= 16'(HALF_CYC)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_valid_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> (valid && !busy));

  assert_launch_clears_valid_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !valid);

endmodule

bind eeprom_addr_loader eal_checker #(.HALF_CYC(HALF_CYC)) u_eal_checker (
  .clk   (clk),
  .rst   (rst),
  .busy  (busy_o),
  .done  (done_o),
  .valid (valid_o),
  .cs    (ee_cs_o),
  .sk    (ee_sk_o),
  .di    (ee_di_o)
);

// File: tb/tb_eeprom_addr_loader.sv
`timescale 1ns/1ps
module tb_eeprom_addr_loader;
  localparam int H         = 4;
  localparam int WORD_STEP = 1 + 2 * 12 + 2 * 17 + 1;   // half-periods per transaction
  localparam int RUN_CYC   = 3 * WORD_STEP * H + 4;      // negedges from launch edge to done seen

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        ee_do_i = 1'b0;
  logic        busy_o, done_o, valid_o, ee_cs_o, ee_sk_o, ee_di_o;
  logic [47:0] mac_o;

  always #2.5 clk = ~clk;

  eeprom_addr_loader #(.HALF_CYC(H)) dut (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .valid_o (valid_o),
    .mac_o   (mac_o),
    .ee_cs_o (ee_cs_o),
    .ee_sk_o (ee_sk_o),
    .ee_di_o (ee_di_o),
    .ee_do_i (ee_do_i)
  );

  int          checks = 0;
  int          failures = 0;
  bit          finished = 0;
  logic [15:0] wmem [3];
  int          exp_addr = 0;
  int          proto_err = 0;
  int          cs_rises = 0;
  int          setup_err = 0;
  int          sk_err = 0;
  int          gap_err = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  function automatic logic [15:0] word_for(input logic [7:0] a);
    if (a < 8'd3) return wmem[a];
    return 16'hDEAD;
  endfunction

  // Behavioural serial EEPROM: decodes the command, returns dummy 0 then data MSB first.
  initial begin : eeprom_model
    int          n;
    logic [11:0] cmd;
    logic [15:0] wd;
    n = 0; cmd = '0; wd = '0;
    forever begin
      @(posedge ee_cs_o or posedge ee_sk_o);
      #1;
      if (!ee_sk_o) begin
        n = 0; cmd = '0; ee_do_i = 1'b0;
      end else begin
        n++;
        if (n <= 12) begin
          cmd = {cmd[10:0], ee_di_o};
          if (n == 12) begin
            if (cmd[11:8] != 4'b0110 || cmd[7:0] != 8'(exp_addr)) proto_err++;
            exp_addr++;
            wd = word_for(cmd[7:0]);
            ee_do_i = 1'b0;
          end
        end else if (n <= 28) begin
          ee_do_i = wd[28 - n];
        end else begin
          ee_do_i = 1'b0;
        end
      end
    end
  end

  // Pin monitor: setup length (R2), clock high time (R4), select gaps (R7).
  initial begin : pin_monitor
    logic psk, pcs;
    int   hi, since, gap;
    bit   first;
    psk = 0; pcs = 0; hi = 0; since = 0; gap = 1000; first = 0;
    forever begin
      @(negedge clk);
      if (rst) begin
        psk = 0; pcs = 0; hi = 0; since = 0; gap = 1000; first = 0;
      end else begin
        if (ee_cs_o && !pcs) begin
          cs_rises++;
          if (gap < H) gap_err++;
          gap = 0; since = 1; first = 1;
          if (ee_sk_o || ee_di_o) setup_err++;
        end else if (first) begin
          if (ee_sk_o) begin
            if (since != 2 * H) setup_err++;
            first = 0;
          end else begin
            if (ee_di_o) setup_err++;
            since++;
          end
        end
        if (!ee_cs_o) gap++;
        if (ee_sk_o) hi++;
        else begin
          if (psk && hi != H) sk_err++;
          hi = 0;
        end
        if (ee_sk_o && !ee_cs_o) setup_err++;
        psk = ee_sk_o; pcs = ee_cs_o;
      end
    end
  end

  task automatic prep(input logic [15:0] w0, input logic [15:0] w1, input logic [15:0] w2);
    wmem[0] = w0; wmem[1] = w1; wmem[2] = w2;
    exp_addr = 0; proto_err = 0; setup_err = 0; sk_err = 0; gap_err = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic check_result(input logic [15:0] w0, input logic [15:0] w1,
                              input logic [15:0] w2, input int n, input int base_rises);
    logic [47:0] exp_mac;
    exp_mac = {w0[7:0], w0[15:8], w1[7:0], w1[15:8], w2[7:0], w2[15:8]};
    chk(n == RUN_CYC, "R9", "cycles to done", 64'(n), 64'(RUN_CYC));
    chk(valid_o && !busy_o, "R9", "valid/busy at done", {valid_o, busy_o}, 2'b10);
    chk(mac_o == exp_mac, "R6", "assembled address", mac_o, exp_mac);
    chk(mac_o[47:32] == {w0[7:0], w0[15:8]}, "R5", "word 0 bit capture", mac_o[47:32], {w0[7:0], w0[15:8]});
    chk(proto_err == 0, "R3", "command/address errors", 64'(proto_err), 0);
    chk(cs_rises - base_rises == 3, "R6", "transaction count", 64'(cs_rises - base_rises), 3);
    chk(setup_err == 0, "R2", "setup errors", 64'(setup_err), 0);
    chk(sk_err == 0, "R4", "clock high errors", 64'(sk_err), 0);
    chk(gap_err == 0, "R7", "select gap errors", 64'(gap_err), 0);
    @(negedge clk);
    chk(!done_o && valid_o, "R9", "done single cycle, valid held", {done_o, valid_o}, 2'b01);
  endtask

  task automatic t_reset_state();
    chk(!ee_cs_o && !ee_sk_o && !ee_di_o, "R1", "pins after reset", {ee_cs_o, ee_sk_o, ee_di_o}, 0);
    chk(!busy_o && !done_o && !valid_o, "R1", "flags after reset", {busy_o, done_o, valid_o}, 0);
    chk(mac_o == 48'd0, "R1", "address after reset", mac_o, 0);
  endtask

  task automatic t_basic(input logic [15:0] w0, input logic [15:0] w1, input logic [15:0] w2);
    int n, base;
    prep(w0, w1, w2);
    base = cs_rises;
    pulse_start();
    n = 1;
    while (!done_o && n < 20000) begin @(negedge clk); n++; end
    check_result(w0, w1, w2, n, base);
  endtask

  task automatic t_relaunch();
    int n, base;
    prep(16'h0F1E, 16'h2D3C, 16'h4B5A);
    base = cs_rises;
    pulse_start();
    chk(!valid_o && busy_o, "R9", "start clears valid", {valid_o, busy_o}, 2'b01);
    chk(mac_o == 48'd0, "R9", "start clears address", mac_o, 0);
    n = 1;
    while (!done_o && n < 20000) begin @(negedge clk); n++; end
    check_result(16'h0F1E, 16'h2D3C, 16'h4B5A, n, base);
  endtask

  task automatic t_busy_start();
    int n, base, after;
    prep(16'hC3A5, 16'h7E81, 16'h0102);
    base = cs_rises;
    pulse_start();
    n = 1;
    while (!done_o && n < 20000) begin
      start_i = (n == 100) || (n == 400) || (n == 600);
      @(negedge clk); n++;
    end
    start_i = 1'b0;
    check_result(16'hC3A5, 16'h7E81, 16'h0102, n, base);
    after = cs_rises;
    repeat (100) @(negedge clk);
    chk(!busy_o && cs_rises == after, "R8", "no restart from ignored start",
        {busy_o, 32'(cs_rises - after)}, 0);
  endtask

  task automatic t_reset_mid();
    int quiet;
    prep(16'h1111, 16'h2222, 16'h3333);
    pulse_start();
    repeat (300) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk(!ee_cs_o && !ee_sk_o && !ee_di_o, "R10", "pins after mid reset", {ee_cs_o, ee_sk_o, ee_di_o}, 0);
    chk(!busy_o && !valid_o && !done_o, "R10", "flags after mid reset", {busy_o, valid_o, done_o}, 0);
    chk(mac_o == 48'd0, "R10", "address after mid reset", mac_o, 0);
    quiet = 0;
    repeat (300) begin @(negedge clk); if (ee_cs_o || busy_o) quiet++; end
    chk(quiet == 0, "R10", "no resumed transaction", 64'(quiet), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired checks=%0d", checks);
    summary();
  end

  initial begin : main
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_basic(16'h1234, 16'h5678, 16'h9ABC);
    t_basic(16'hFFFF, 16'h0000, 16'hA55A);
    t_basic(16'h8001, 16'h4002, 16'h0180);
    t_relaunch();
    t_busy_start();
    t_reset_mid();
    t_basic(16'h6B2F, 16'hE0D1, 16'h5C47);
    summary();
  end

endmodule